// File: doc/BRIEF.md
# Edge and Window Fail Accumulator

This block judges the output of one tester pin against what the pattern expects. Each clock it takes the comparator pair for the pin: one bit set when the pin is above the high threshold and one bit set when it is above the low threshold. It also takes up to four timing edges. Each edge carries a four-bit event code. Strobe codes check the level in the cycle the edge fires. Window codes on edges 0 and 2 open a window that watches every qualified sample until edge 1 or edge 3 closes it. Drive codes, the "compare unknown" code and the empty code make no check.

The result is a four-bit fail vector, registered on the period clock and held for a single cycle. A window fail appears only on the bit of its closing edge. A per-bit mask keeps a fail out of a sticky fail flag and out of a saturating per-pin fail counter. The mask never hides the live fail vector, so match-mode logic downstream still sees every mismatch. A synchronous clear empties the flag and the counter.

Top module: `fail_accum`

## Requirements
- R1: After reset `failVec` is 0, `failSticky` is 0, `failCount` is 0 and both windows are closed.
- R2: Event codes 8, 9, 10 and 11 are single-edge strobes expecting low, high, midband and valid. Low means `cmpLo`=0. High means `cmpHi`=1. Midband means `cmpLo`=1 and `cmpHi`=0. Valid means low or high. A mismatch on edge n sets `failVec[n]` in the cycle after the edge.
- R3: Codes 0 to 7 make no check: 0 is empty, 1 to 6 are drive actions and 7 is compare unknown. They never raise a fail bit.
- R4: Codes 12 to 15 on edge 0 (or edge 2) open a window expecting low, high, midband or valid, in that order. Every qualified cycle from the opening cycle through the closing cycle is sampled. Any mismatch is latched. Any event firing on edge 1 (or edge 3) while the window is open closes it and reports the latched result. On the odd edges, window codes open nothing.
- R5: `failVec[0]` and `failVec[2]` are the edge 0 and edge 2 strobe fails. `failVec[1]` is the edge 1 strobe fail ORed with the 0/1 window fail. `failVec[3]` is the edge 3 strobe fail ORed with the 2/3 window fail.
- R6: While `patValid` is 0, fired events are ignored, no window samples are taken, open windows stay open and no fail is produced.
- R7: `failMask[n]` stops fail bit n from setting `failSticky` or counting. It does not change `failVec`.
- R8: `failSticky` is set one cycle after any unmasked fail and stays set until cleared.
- R9: `failCount` rises by one for each cycle with at least one unmasked fail, however many bits fail, and saturates at 2^CNT_W-1.
- R10: `clearAcc` zeroes `failSticky` and `failCount` on the next edge and takes priority over a fail in the same cycle.
- R11: A fail bit is 1 for exactly the one cycle after its cause and reads 0 in any cycle without a new fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Period clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clearAcc | input | 1 | Synchronous clear of the sticky flag and the counter |
| patValid | input | 1 | Qualifies this cycle's events and samples |
| evtFire | input | 4 | Edge n fires this cycle |
| evtCode | input | 16 | Event code of edge n in bits [4n+3:4n] |
| failMask | input | 4 | Per-bit accumulation mask |
| cmpHi | input | 1 | Pin above the high threshold |
| cmpLo | input | 1 | Pin above the low threshold |
| failVec | output | 4 | Registered per-cycle fail vector |
| failSticky | output | 1 | Accumulated fail flag |
| failCount | output | CNT_W | Saturating fail counter |

## Verification
The strobe codes are driven at low, midband and high comparator levels. This shows that each expected level is decoded to its own threshold test rather than to a neighbour's. Windows are exercised in four ways: opened with a failing sample and closed clean, opened and closed on clean samples, opened and closed in the same cycle, and held across a cycle with `patValid` low. Together these separate latching from sampling, and sampling from qualification. Odd-edge strobes are combined with window closes to expose a missing OR. The mask patterns, clear-with-fail and a run past the counter limit separate the live vector from accumulation.

// File: rtl/fail_accum_pkg.sv
package fail_accum_pkg;

  localparam int EDGE_PAIRS = 2;
  localparam int NUM_EDGES  = 2 * EDGE_PAIRS;
  localparam int CODE_W     = 4;

  // expected level, taken from the two low code bits of strobe/window codes
  typedef enum logic [1:0] {
    LVL_LO    = 2'd0,
    LVL_HI    = 2'd1,
    LVL_MID   = 2'd2,
    LVL_VALID = 2'd3
  } expLvl_e;

  // code classes by the two high code bits
  localparam logic [1:0] CLS_STROBE = 2'b10;
  localparam logic [1:0] CLS_WINDOW = 2'b11;

  typedef struct packed {
    logic [NUM_EDGES-1:0] failNow;
    logic [NUM_EDGES-1:0] accumEn;
  } failStrobe_t;

  function automatic logic levelMatch(input expLvl_e lvl, input logic hi, input logic lo);
    unique case (lvl)
      LVL_LO:    levelMatch = !lo;
      LVL_HI:    levelMatch = hi;
      LVL_MID:   levelMatch = lo && !hi;
      default:   levelMatch = !lo || hi;
    endcase
  endfunction

endpackage

// File: rtl/fail_accum_window.sv
module fail_accum_window
  import fail_accum_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              openFire,
  input  logic [CODE_W-1:0] openCode,
  input  logic              closeFire,
  input  logic              cmpHi,
  input  logic              cmpLo,
  input  logic              sampleEn,
  output logic              winFail
);

  logic    isOpen;
  logic    missSeen;
  expLvl_e expReg;

  logic    openNow;
  logic    active;
  expLvl_e expNow;
  logic    miss;
  logic    closeNow;
  logic    carried;

  always_comb begin
    openNow  = sampleEn && openFire && (openCode[CODE_W-1:CODE_W-2] == CLS_WINDOW);
    active   = openNow || isOpen;
    expNow   = openNow ? expLvl_e'(openCode[1:0]) : expReg;
    miss     = sampleEn && active && !levelMatch(expNow, cmpHi, cmpLo);
    closeNow = sampleEn && closeFire && active;
    carried  = openNow ? 1'b0 : missSeen;
    winFail  = closeNow && (carried || miss);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isOpen   <= 1'b0;
      missSeen <= 1'b0;
      expReg   <= LVL_LO;
    end else if (closeNow) begin
      isOpen   <= 1'b0;
      missSeen <= 1'b0;
    end else if (openNow) begin
      isOpen   <= 1'b1;
      expReg   <= expNow;
      missSeen <= miss;
    end else if (isOpen && sampleEn) begin
      missSeen <= missSeen || miss;
    end
  end

endmodule

// File: rtl/fail_accum_eval.sv
module fail_accum_eval
  import fail_accum_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        patValid,
  input  logic [NUM_EDGES-1:0]        evtFire,
  input  logic [NUM_EDGES*CODE_W-1:0] evtCode,
  input  logic [NUM_EDGES-1:0]        failMask,
  input  logic                        cmpHi,
  input  logic                        cmpLo,
  output failStrobe_t                 strobe
);

  logic [NUM_EDGES-1:0]  fireQ;
  logic [NUM_EDGES-1:0]  edgeFail;
  logic [EDGE_PAIRS-1:0] pairWinFail;

  assign fireQ = evtFire & {NUM_EDGES{patValid}};

  for (genvar e = 0; e < NUM_EDGES; e++) begin : g_edge
    logic [CODE_W-1:0] code;
    assign code = evtCode[e*CODE_W +: CODE_W];
    assign edgeFail[e] = fireQ[e] && (code[CODE_W-1:CODE_W-2] == CLS_STROBE)
                         && !levelMatch(expLvl_e'(code[1:0]), cmpHi, cmpLo);
  end

  for (genvar p = 0; p < EDGE_PAIRS; p++) begin : g_pair
    fail_accum_window u_win (
      .clk      (clk),
      .rstN     (rstN),
      .openFire (fireQ[2*p]),
      .openCode (evtCode[2*p*CODE_W +: CODE_W]),
      .closeFire(fireQ[2*p+1]),
      .cmpHi    (cmpHi),
      .cmpLo    (cmpLo),
      .sampleEn (patValid),
      .winFail  (pairWinFail[p])
    );
    assign strobe.failNow[2*p]   = edgeFail[2*p];
    assign strobe.failNow[2*p+1] = edgeFail[2*p+1] || pairWinFail[p];
  end

  assign strobe.accumEn = strobe.failNow & ~failMask;

endmodule

// File: rtl/fail_accum_store.sv
module fail_accum_store
  import fail_accum_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clearAcc,
  input  failStrobe_t          strobe,
  output logic [NUM_EDGES-1:0] failVec,
  output logic                 failSticky,
  output logic [CNT_W-1:0]     failCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic anyAccum;
  assign anyAccum = |strobe.accumEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failVec    <= '0;
      failSticky <= 1'b0;
      failCount  <= '0;
    end else begin
      failVec <= strobe.failNow;
      if (clearAcc) begin
        failSticky <= 1'b0;
        failCount  <= '0;
      end else if (anyAccum) begin
        failSticky <= 1'b1;
        if (failCount != CNT_MAX) failCount <= failCount + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fail_accum.sv
module fail_accum
  import fail_accum_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearAcc,
  input  logic             patValid,
  input  logic [3:0]       evtFire,
  input  logic [15:0]      evtCode,
  input  logic [3:0]       failMask,
  input  logic             cmpHi,
  input  logic             cmpLo,
  output logic [3:0]       failVec,
  output logic             failSticky,
  output logic [CNT_W-1:0] failCount
);

  failStrobe_t strobe;

  fail_accum_eval u_eval (
    .clk     (clk),
    .rstN    (rstN),
    .patValid(patValid),
    .evtFire (evtFire),
    .evtCode (evtCode),
    .failMask(failMask),
    .cmpHi   (cmpHi),
    .cmpLo   (cmpLo),
    .strobe  (strobe)
  );

  fail_accum_store #(.CNT_W(CNT_W)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .clearAcc  (clearAcc),
    .strobe    (strobe),
    .failVec   (failVec),
    .failSticky(failSticky),
    .failCount (failCount)
  );

endmodule

// File: rtl/fail_accum_chk.sv
module fail_accum_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             clearAcc,
  input logic             patValid,
  input logic [3:0]       failMask,
  input logic [3:0]       failVec,
  input logic             failSticky,
  input logic [CNT_W-1:0] failCount
);

  // R6
  fail_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (failVec != 4'd0) |-> $past(patValid));

  // R10
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(clearAcc) |-> (failCount == '0 && !failSticky));

  // R8
  sticky_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(failSticky) && !$past(clearAcc)) |-> failSticky);

  // R9
  count_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clearAcc) |-> (failCount >= $past(failCount)));

  // R9
  count_saturates_chk: assert property (@(posedge clk) disable iff (!rstN)
    (failCount == {CNT_W{1'b1}} && !clearAcc) |=> (failCount == {CNT_W{1'b1}}));

  // R7
  sticky_needs_unmasked_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failSticky) |-> ((failVec & ~$past(failMask)) != 4'd0));

endmodule

bind fail_accum fail_accum_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clearAcc  (clearAcc),
  .patValid  (patValid),
  .failMask  (failMask),
  .failVec   (failVec),
  .failSticky(failSticky),
  .failCount (failCount)
);

// File: tb/fail_accum_test.sv
module fail_accum_test;

  localparam int CNT_W = 4;

  typedef struct packed {
    logic        valid;
    logic [3:0]  fire;
    logic [15:0] codes;
    logic        hi;
    logic        lo;
    logic [3:0]  expVec;
  } vec_t;

  // levels: low hi0 lo0, mid hi0 lo1, high hi1 lo1
  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 4'b0001, 16'h0008, 1'b0, 1'b0, 4'h0}, // R2 strobe low ok
    '{1'b1, 4'b0001, 16'h0008, 1'b1, 1'b1, 4'h1}, // R2 strobe low at high
    '{1'b1, 4'b0010, 16'h0090, 1'b0, 1'b1, 4'h2}, // R2 strobe high at mid
    '{1'b1, 4'b0100, 16'h0A00, 1'b0, 1'b1, 4'h0}, // R2 strobe mid ok
    '{1'b1, 4'b1000, 16'hB000, 1'b0, 1'b1, 4'h8}, // R2 strobe valid at mid
    '{1'b1, 4'b0100, 16'h0900, 1'b0, 1'b0, 4'h4}, // R2 strobe high at low
    '{1'b1, 4'b1111, 16'h7777, 1'b0, 1'b1, 4'h0}, // R3 compare unknown
    '{1'b1, 4'b1111, 16'h6543, 1'b1, 1'b1, 4'h0}, // R3 drive codes
    '{1'b0, 4'b1111, 16'h8888, 1'b1, 1'b1, 4'h0}, // R6 invalid ignored
    '{1'b1, 4'b0001, 16'h000C, 1'b0, 1'b0, 4'h0}, // R4 open low window
    '{1'b1, 4'b0000, 16'h0000, 1'b1, 1'b1, 4'h0}, // R4 miss latched
    '{1'b1, 4'b0010, 16'h0070, 1'b0, 1'b0, 4'h2}, // R4 reported on close
    '{1'b1, 4'b0001, 16'h000D, 1'b1, 1'b1, 4'h0}, // R4 open high window
    '{1'b1, 4'b0010, 16'h0070, 1'b1, 1'b1, 4'h0}, // R4 clean close
    '{1'b1, 4'b1100, 16'h7E00, 1'b1, 1'b1, 4'h8}, // R5 same-cycle window 2/3
    '{1'b1, 4'b0001, 16'h000F, 1'b0, 1'b0, 4'h0}, // R4 open valid window
    '{1'b1, 4'b0010, 16'h0080, 1'b1, 1'b1, 4'h2}, // R5 edge1 strobe on close
    '{1'b1, 4'b0001, 16'h000C, 1'b0, 1'b0, 4'h0}, // R6 open low window
    '{1'b0, 4'b0000, 16'h0000, 1'b1, 1'b1, 4'h0}, // R6 unsampled
    '{1'b1, 4'b0010, 16'h0070, 1'b0, 1'b0, 4'h0}, // R6 close clean
    '{1'b1, 4'b0010, 16'h00C0, 1'b1, 1'b1, 4'h0}, // R4 odd-edge window code
    '{1'b1, 4'b0100, 16'h0C00, 1'b1, 1'b1, 4'h0}, // R4 open 2/3 with miss
    '{1'b1, 4'b1000, 16'h9000, 1'b1, 1'b1, 4'h8}  // R5 window fail on bit 3
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             clearAcc = 1'b0;
  logic             patValid = 1'b0;
  logic [3:0]       evtFire = '0;
  logic [15:0]      evtCode = '0;
  logic [3:0]       failMask = '0;
  logic             cmpHi = 1'b0;
  logic             cmpLo = 1'b0;
  logic [3:0]       failVec;
  logic             failSticky;
  logic [CNT_W-1:0] failCount;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fail_accum #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .clearAcc(clearAcc), .patValid(patValid),
    .evtFire(evtFire), .evtCode(evtCode), .failMask(failMask),
    .cmpHi(cmpHi), .cmpLo(cmpLo),
    .failVec(failVec), .failSticky(failSticky), .failCount(failCount)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] f, input logic [15:0] c,
                       input logic h, input logic l, input logic [3:0] m, input logic clr);
    patValid = v; evtFire = f; evtCode = c; cmpHi = h; cmpLo = l;
    failMask = m; clearAcc = clr;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 vec", int'(failVec), 0);
    check("R1 sticky", int'(failSticky), 0);
    check("R1 count", int'(failCount), 0);
    rstN = 1'b1;
    step();
    check("R1 vec after release", int'(failVec), 0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].valid, TBL[i].fire, TBL[i].codes, TBL[i].hi, TBL[i].lo, 4'h0, 1'b0);
      step();
      check($sformatf("table %0d", i), int'(failVec), int'(TBL[i].expVec));
    end

    drive(1'b1, 4'h0, 16'h0, 1'b1, 1'b1, 4'h0, 1'b0);
    step();
    check("R11 idle clears vec", int'(failVec), 0);

    drive(1'b1, 4'h0, 16'h0, 1'b1, 1'b1, 4'h0, 1'b1);
    step();
    check("R10 count cleared", int'(failCount), 0);
    check("R10 sticky cleared", int'(failSticky), 0);

    drive(1'b1, 4'b0001, 16'h0008, 1'b1, 1'b1, 4'b0001, 1'b0);
    step();
    check("R7 masked vec live", int'(failVec), 1);
    check("R7 masked sticky", int'(failSticky), 0);
    check("R7 masked count", int'(failCount), 0);

    drive(1'b1, 4'b0001, 16'h0008, 1'b1, 1'b1, 4'b0010, 1'b0);
    step();
    check("R8 sticky set", int'(failSticky), 1);
    check("R9 count one", int'(failCount), 1);

    drive(1'b1, 4'b1111, 16'h8888, 1'b1, 1'b1, 4'h0, 1'b0);
    step();
    check("R5 all bits", int'(failVec), 15);
    check("R9 one per cycle", int'(failCount), 2);

    drive(1'b1, 4'h0, 16'h0, 1'b1, 1'b1, 4'h0, 1'b0);
    step();
    check("R8 sticky holds", int'(failSticky), 1);
    check("R11 vec one cycle", int'(failVec), 0);
    check("R9 count holds", int'(failCount), 2);

    drive(1'b1, 4'b0001, 16'h0008, 1'b1, 1'b1, 4'h0, 1'b1);
    step();
    check("R10 vec with clear", int'(failVec), 1);
    check("R10 clear wins count", int'(failCount), 0);
    check("R10 clear wins sticky", int'(failSticky), 0);

    drive(1'b1, 4'b0001, 16'h0008, 1'b1, 1'b1, 4'h0, 1'b0);
    for (int k = 0; k < 20; k++) step();
    check("R9 saturated", int'(failCount), 15);
    step();
    check("R9 stays saturated", int'(failCount), 15);

    drive(1'b0, 4'h0, 16'h0, 1'b0, 1'b0, 4'h0, 1'b0);
    step();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule